// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block sits between a group of peripheral devices and a processor that has a single interrupt input. Each device raises its request by pulling its own line low. The block merges every request that is currently allowed into one active-high interrupt line. When the processor acknowledges by driving its acknowledge line low, the block puts an 8-bit vector onto the data bus that names the chosen device: a fixed base of 0x20 plus the device index. Index 0 has the highest priority.

The block records which devices are in service. A device that is being serviced masks itself and every device of lower priority, so only a more urgent device can pre-empt it. A one-cycle end-of-service strobe from the processor retires the most urgent device in service. When an acknowledge completes, the block sends the chosen device a one-cycle clear pulse so that the device can drop its request.

The acknowledge and end-of-service inputs are synchronous to the block clock. The bus is modelled as a data output with a separate drive-enable output, and the data output is zero while the bus is released.

Top module: `irq_vector_gen`

## Requirements
- R1: Request inputs are active low. `int_o` is 1 exactly when at least one request input is 0 and that request is not masked; it follows the inputs without a clock delay.
- R2: Among the unmasked active requests, the lowest index wins, and its vector is 0x20 plus that index (index 0 gives 0x20, index 7 gives 0x27).
- R3: While any in-service bit is set, a request is masked if its index is greater than or equal to the lowest set in-service index. A request with a smaller index is not masked and pre-empts.
- R4: `vec_oe_o` is 1 only while `ack_n_i` is 0. While it is 0, `vec_o` is 0x00.
- R5: In the first clock cycle of an acknowledge, the vector follows the current winner. That choice is captured at the clock edge that ends this cycle and is held on the bus for the rest of the acknowledge, even if the requests change.
- R6: At the first clock edge that sees `ack_n_i` high again after an acknowledge, the in-service bit of the captured device is set.
- R7: In the clock cycle after that edge, `clr_o` carries a one-hot pulse at the captured device's bit, for exactly one cycle.
- R8: When `eos_i` is 1 at a clock edge, the lowest-indexed set in-service bit is cleared. If no bit is set, the strobe has no effect.
- R9: An acknowledge with no unmasked request returns vector 0x28, sets no in-service bit and issues no clear pulse.
- R10: After reset, no bit is in service, `clr_o` is 0, and no request is masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_n_i | input | 8 | Device request lines, active low, bit 0 most urgent |
| ack_n_i | input | 1 | Processor acknowledge, active low, synchronous |
| eos_i | input | 1 | One-cycle end-of-service strobe |
| int_o | output | 1 | Merged interrupt request to the processor, active high |
| vec_o | output | 8 | Vector byte, 0x00 while the bus is released |
| vec_oe_o | output | 1 | Bus drive enable, high while acknowledge is low |
| clr_o | output | 8 | One-cycle per-device clear pulse after acknowledge |

## Verification
The assertions assume that `ack_n_i` and `eos_i` change only between clock edges and that a device's clear pulse may come before it releases its request. They also assume that an acknowledge lasts at least two cycles, so the captured vector is visible while the bus is driven. The stimulus drives every input on the falling clock edge, keeps each acknowledge low for two cycles and each end-of-service strobe high for one cycle, and releases a request only after its clear pulse. Pre-emption is tested by stacking in-service levels with requests that arrive while a lower-priority device is still in service.

// File: rtl/ivg_pkg.sv
package ivg_pkg;

  // Phases of one acknowledge handshake
  typedef enum logic [0:0] {
    ACK_IDLE = 1'b0,
    ACK_HOLD = 1'b1
  } ack_phase_e;

  // Index width for a given number of sources
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ivg_prio_enc.sv
module ivg_prio_enc #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IDX_W = ivg_pkg::idx_width(WIDTH)
) (
  input  logic [WIDTH-1:0] req,
  output logic [IDX_W-1:0] idx,
  output logic             vld
);

  // Walk from the least urgent bit down so the lowest index wins.
  always_comb begin
    idx = '0;
    vld = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        vld = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ivg_svc_mask.sv
module ivg_svc_mask #(
  parameter int unsigned N_SRC = 8
) (
  input  logic [N_SRC-1:0] in_svc,
  output logic [N_SRC-1:0] allowed
);

  // A source is allowed only if no in-service bit is set at or above
  // its own priority (index 0 to its own index).
  logic [N_SRC:0] blocked;

  assign blocked[0] = 1'b0;

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_prefix
      assign blocked[g+1] = blocked[g] | in_svc[g];
      assign allowed[g]   = ~blocked[g+1];
    end
  endgenerate

endmodule

// File: rtl/ivg_ack_ctl.sv
module ivg_ack_ctl #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = ivg_pkg::idx_width(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_n_i,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             win_vld,
  output logic             in_ack,
  output logic [IDX_W-1:0] hold_idx,
  output logic             hold_vld,
  output logic             done_stb
);
  import ivg_pkg::*;

  ack_phase_e       phase_q, phase_d;
  logic             cap_en;
  logic [IDX_W-1:0] hold_idx_q;
  logic             hold_vld_q;

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      ACK_IDLE: if (!ack_n_i) phase_d = ACK_HOLD;
      ACK_HOLD: if (ack_n_i)  phase_d = ACK_IDLE;
      default:                phase_d = ACK_IDLE;
    endcase
  end

  assign cap_en   = (phase_q == ACK_IDLE) && !ack_n_i;
  assign done_stb = (phase_q == ACK_HOLD) && ack_n_i;
  assign in_ack   = (phase_q == ACK_HOLD);
  assign hold_idx = hold_idx_q;
  assign hold_vld = hold_vld_q;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ACK_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_idx_q <= '0;
      hold_vld_q <= 1'b0;
    end else if (cap_en) begin
      hold_idx_q <= win_idx;
      hold_vld_q <= win_vld;
    end
  end

  // R5: the captured choice does not move during a held acknowledge
  assert_hold_stable_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    (phase_q == ACK_HOLD && !ack_n_i) |=> ($stable(hold_idx_q) && $stable(hold_vld_q))
  );

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
  parameter int unsigned N_SRC    = 8,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 32'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_n_i,
  input  logic             ack_n_i,
  input  logic             eos_i,
  output logic             int_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_oe_o,
  output logic [N_SRC-1:0] clr_o
);
  localparam int unsigned IDX_W = ivg_pkg::idx_width(N_SRC);
  localparam logic [VEC_W-1:0] VEC_NONE = VEC_W'(VEC_BASE + N_SRC);

  logic [N_SRC-1:0] in_svc_q, in_svc_d;
  logic [N_SRC-1:0] clr_q, clr_d;
  logic [N_SRC-1:0] req_act, allowed, elig;
  logic [IDX_W-1:0] win_idx, svc_idx, hold_idx, cur_idx;
  logic             win_vld, svc_vld, hold_vld, cur_vld;
  logic             in_ack, done_stb, svc_en, set_fire;
  logic [N_SRC-1:0] set_vec, eos_vec;
  logic [VEC_W-1:0] vec_val;

  // Request merge and masking
  assign req_act = ~req_n_i;

  ivg_svc_mask #(.N_SRC(N_SRC)) u_mask (
    .in_svc  (in_svc_q),
    .allowed (allowed)
  );

  assign elig  = req_act & allowed;
  assign int_o = |elig;

  ivg_prio_enc #(.WIDTH(N_SRC)) u_win_enc (
    .req (elig),
    .idx (win_idx),
    .vld (win_vld)
  );

  // Most urgent in-service level, retired by end-of-service
  ivg_prio_enc #(.WIDTH(N_SRC)) u_svc_enc (
    .req (in_svc_q),
    .idx (svc_idx),
    .vld (svc_vld)
  );

  ivg_ack_ctl #(.N_SRC(N_SRC)) u_ack (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_n_i  (ack_n_i),
    .win_idx  (win_idx),
    .win_vld  (win_vld),
    .in_ack   (in_ack),
    .hold_idx (hold_idx),
    .hold_vld (hold_vld),
    .done_stb (done_stb)
  );

  // Vector bus
  assign cur_idx  = in_ack ? hold_idx : win_idx;
  assign cur_vld  = in_ack ? hold_vld : win_vld;
  assign vec_val  = cur_vld ? (VEC_W'(VEC_BASE) + VEC_W'(cur_idx)) : VEC_NONE;
  assign vec_oe_o = ~ack_n_i;
  assign vec_o    = ack_n_i ? '0 : vec_val;

  // One-hot decode of captured and retiring indices
  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_dec
      assign set_vec[g] = (hold_idx == IDX_W'(g));
      assign eos_vec[g] = svc_vld && (svc_idx == IDX_W'(g));
    end
  endgenerate

  assign set_fire = done_stb && hold_vld;
  assign svc_en   = eos_i || set_fire;

  // Next-state for service tracking and clear pulse
  always_comb begin
    in_svc_d = in_svc_q;
    if (eos_i)    in_svc_d = in_svc_d & ~eos_vec;
    if (set_fire) in_svc_d = in_svc_d | set_vec;
    clr_d = set_fire ? set_vec : '0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_svc_q <= '0;
    end else if (svc_en) begin
      in_svc_q <= in_svc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= '0;
    end else begin
      clr_q <= clr_d;
    end
  end

  assign clr_o = clr_q;

  // R7: clear pulse addresses at most one device
  assert_clr_onehot_R7: assert property (
    @(posedge clk) disable iff (!rst_n) $onehot0(clr_o)
  );

  // R7: clear pulse lasts a single cycle
  assert_clr_single_R7: assert property (
    @(posedge clk) disable iff (!rst_n) (|clr_o) |=> (clr_o == '0)
  );

  // R6: at most one new in-service level per cycle
  assert_svc_one_new_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    $countones(in_svc_q & ~$past(in_svc_q)) <= 1
  );

  // R3: a newly serviced level is always more urgent than the ones in service
  assert_preempt_order_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    (|(in_svc_q & ~$past(in_svc_q))) |->
      ((in_svc_q & ~$past(in_svc_q)) < ($past(in_svc_q) & ~($past(in_svc_q) - 1'b1))
       || ($past(in_svc_q) == '0))
  );

endmodule

// File: tb/tb_irq_vector_gen.sv
module tb_irq_vector_gen;

  logic       clk;
  logic       rst_n;
  logic [7:0] req_n_i;
  logic       ack_n_i;
  logic       eos_i;
  logic       int_o;
  logic [7:0] vec_o;
  logic       vec_oe_o;
  logic [7:0] clr_o;

  int n_chk;
  int n_fail;
  bit finished;

  irq_vector_gen dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_n_i  (req_n_i),
    .ack_n_i  (ack_n_i),
    .eos_i    (eos_i),
    .int_o    (int_o),
    .vec_o    (vec_o),
    .vec_oe_o (vec_oe_o),
    .clr_o    (clr_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Vector entries: {req_n, expected int, expected vector}
  localparam logic [16:0] TBL [8] = '{
    {8'hFE, 1'b1, 8'h20},
    {8'h7F, 1'b1, 8'h27},
    {8'hF0, 1'b1, 8'h20},
    {8'h0F, 1'b1, 8'h24},
    {8'hBF, 1'b1, 8'h26},
    {8'hFF, 1'b0, 8'h28},
    {8'h00, 1'b1, 8'h20},
    {8'hEF, 1'b1, 8'h24}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Full acknowledge: two low cycles, then release, then clear pulse checks
  task automatic do_ack(input logic [7:0] exp_vec, input logic [7:0] exp_clr);
    @(negedge clk); ack_n_i = 1'b0;
    #5;
    chk("R4 oe during ack", 32'(vec_oe_o), 32'd1);
    chk("R2 vector first cycle", 32'(vec_o), 32'(exp_vec));
    @(negedge clk); #5;
    chk("R5 vector held", 32'(vec_o), 32'(exp_vec));
    @(negedge clk); ack_n_i = 1'b1;
    #5;
    chk("R4 bus released oe", 32'(vec_oe_o), 32'd0);
    chk("R4 bus released data", 32'(vec_o), 32'd0);
    @(negedge clk); #5;
    chk("R7 clear pulse", 32'(clr_o), 32'(exp_clr));
    @(negedge clk); #5;
    chk("R7 clear ends", 32'(clr_o), 32'd0);
  endtask

  task automatic pulse_eos();
    @(negedge clk); eos_i = 1'b1;
    @(negedge clk); eos_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    req_n_i = 8'hFF; ack_n_i = 1'b1; eos_i = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #5;
    // R10: reset state
    chk("R10 int idle", 32'(int_o), 32'd0);
    chk("R10 clr idle", 32'(clr_o), 32'd0);
    chk("R4 oe idle", 32'(vec_oe_o), 32'd0);
    chk("R4 vec idle", 32'(vec_o), 32'd0);

    // Table walk: R1, R2, R6, R7, R8, R9
    for (int k = 0; k < 8; k++) begin
      logic [7:0] rq; logic ei; logic [7:0] ev; logic [7:0] ec;
      {rq, ei, ev} = TBL[k];
      ec = ei ? (8'd1 << (ev - 8'h20)) : 8'd0;
      @(negedge clk); req_n_i = rq;
      #5;
      chk("R1 merged request", 32'(int_o), 32'(ei));
      do_ack(ev, ec);
      #1;
      chk("R6 serviced level masks itself", 32'(int_o), 32'd0);
      @(negedge clk); req_n_i = 8'hFF;
      pulse_eos();
      #5;
      chk("R8 no stale mask", 32'(int_o), 32'd0);
    end

    // R9: spurious acknowledge leaves nothing in service
    @(negedge clk); req_n_i = 8'h7F; #5;
    chk("R9 no service after spurious", 32'(int_o), 32'd1);
    @(negedge clk); req_n_i = 8'hFF;

    // R3: pre-emption and masking
    @(negedge clk); req_n_i = 8'hDF;               // source 5
    do_ack(8'h25, 8'h20);
    @(negedge clk); req_n_i = 8'h7F; #5;           // source 7, lower
    chk("R3 lower masked", 32'(int_o), 32'd0);
    @(negedge clk); req_n_i = 8'hDF; #5;           // same level
    chk("R3 same level masked", 32'(int_o), 32'd0);
    @(negedge clk); req_n_i = 8'h7B; #5;           // sources 2 and 7
    chk("R3 higher pre-empts", 32'(int_o), 32'd1);
    do_ack(8'h22, 8'h04);
    @(negedge clk); req_n_i = 8'h7F;
    pulse_eos();                                    // retires 2
    #5;
    chk("R8 level 5 still masks 7", 32'(int_o), 32'd0);
    @(negedge clk); req_n_i = 8'hF7; #5;            // source 3 above 5
    chk("R8 level 2 retired, 3 allowed", 32'(int_o), 32'd1);
    @(negedge clk); req_n_i = 8'h7F;
    pulse_eos();                                    // retires 5
    #5;
    chk("R8 level 5 retired", 32'(int_o), 32'd1);
    pulse_eos();                                    // nothing in service
    #5;
    chk("R8 empty strobe no effect", 32'(int_o), 32'd1);

    // R5: vector stays fixed when a more urgent request arrives mid-acknowledge
    @(negedge clk); req_n_i = 8'hEF; ack_n_i = 1'b0; #5;
    chk("R5 first cycle winner", 32'(vec_o), 32'h24);
    @(negedge clk); req_n_i = 8'hEE; #5;
    chk("R5 held despite new request", 32'(vec_o), 32'h24);
    @(negedge clk); ack_n_i = 1'b1;
    @(negedge clk); #5;
    chk("R7 clear at captured device", 32'(clr_o), 32'h10);
    chk("R3 source 0 pre-empts 4", 32'(int_o), 32'd1);

    // R10: reset clears in-service state
    @(negedge clk); req_n_i = 8'hEF; #5;
    chk("R3 source 4 masked before reset", 32'(int_o), 32'd0);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #5;
    chk("R10 mask cleared by reset", 32'(int_o), 32'd1);
    chk("R10 clr cleared by reset", 32'(clr_o), 32'd0);

    @(negedge clk);
    finish_run();
  end

endmodule